// File: doc/BRIEF.md
# Keyed Digest Message Assembler

This block prepares the input of an external SHA-256 core for a challenge-response authentication engine. One start pulse captures a 256-bit key, a 256-bit challenge, the command opcode, a mode byte, a key identifier and the device identity: 88 fuse bits, a fuse manufacturer byte, a 32-bit fuse serial, a 16-bit ROM manufacturer code and a 16-bit ROM serial. From these it forms two 512-bit message blocks.

The first block is the key followed by the challenge. The second block has three parts:

- The command and identity fields. Some of them are forced to zero by the mode byte and by a lock fuse, so the same engine can produce a per-device digest or a shared one.
- The standard SHA-256 padding.
- The 64-bit length field, which states the 704 message bits.

Each block is presented on a 512-bit output with a valid/ready handshake and a block index. A mode byte that uses reserved bits is refused with a one-cycle flag, and no block is produced.

Top module: `digest_msg_builder`

## Requirements
- R1: After reset, `blk_valid` and `bad_mode` are low.
- R2: The cycle after an accepted start, block 0 is presented with `blk_idx` = 0. In this block, `blk_data[511:256]` holds the key and `blk_data[255:0]` holds the challenge.
- R3: Block 1 places its fields at these bit positions:
  - opcode at [511:504]
  - mode at [503:496]
  - key ID at [495:480]
  - fuses 63..0 at [479:416]
  - fuses 87..64 at [415:392]
  - fuse manufacturer byte at [391:384]
  - fuse serial at [383:352]
  - ROM manufacturer code at [351:336]
  - ROM serial at [335:320]
- R4: In block 1, bit 319 is 1, bits [318:64] are 0, and bits [63:0] hold the value 704.
- R5: Both serial fields are copied only when mode bit 6 is 1. Otherwise they are zero.
- R6: The lock fuse is fuse 87, and it counts as burned when it reads 0. Fuses 63..0 are copied when mode bit 5 is 1 and the lock fuse is burned. Otherwise they are zero.
- R7: When mode bit 4 is 1 and the lock fuse is burned, fuses 87..0 are all copied and bit 5 has no effect. Fuses 87..64 are zero in every other case.
- R8: The fuse manufacturer byte and the ROM manufacturer code are always copied unchanged.
- R9: A start whose mode has bit 7 set or any of bits 3..0 set raises `bad_mode` for exactly one cycle, the cycle after the start. No block is presented.
- R10: Block 1 is presented only after block 0 has been accepted. While `blk_valid` is high and `blk_ready` is low, the data and the index hold. After block 1 is accepted, `blk_valid` falls.
- R11: A start while blocks are pending is ignored, and input changes after the capture do not alter the blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the inputs and begin a message |
| key | input | 256 | Selected key |
| challenge | input | 256 | Challenge |
| opcode | input | 8 | Command opcode |
| mode | input | 8 | Mode byte selecting the included fields |
| key_id | input | 16 | Key identifier |
| fuse | input | 88 | Fuse bits 87..0, fuse n at bit n |
| fuse_mfr | input | 8 | Fuse manufacturer byte |
| fuse_sn | input | 32 | Fuse serial |
| rom_mfr | input | 16 | ROM manufacturer code |
| rom_sn | input | 16 | ROM serial |
| blk_ready | input | 1 | Hash core accepts the presented block |
| blk_valid | output | 1 | A block is presented |
| blk_idx | output | 1 | Index of the presented block |
| blk_data | output | 512 | Presented block |
| bad_mode | output | 1 | One-cycle flag for a refused mode byte |

## Verification
The hardest condition to reach is a second start arriving while block 0 is stalled by a low ready. That start carries a reserved mode and a different key. If the capture were not blocked, the refusal flag would fire or the pending blocks would change.

The bench reaches this state by holding ready low and pulsing start with the altered inputs. It then checks that neither block changed.

The masking rules are covered by a table of mode and lock combinations. The table includes bit 5 together with bit 4, and both of them with the lock fuse unburned.

// File: rtl/digest_msg_builder.sv
module digest_msg_builder #(
  parameter int KEY_W  = 256,
  parameter int CHAL_W = 256,
  parameter int FUSE_N = 88,
  parameter int LOCK_FUSE = 87
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [KEY_W-1:0]     key,
  input  logic [CHAL_W-1:0]    challenge,
  input  logic [7:0]           opcode,
  input  logic [7:0]           mode,
  input  logic [15:0]          key_id,
  input  logic [FUSE_N-1:0]    fuse,
  input  logic [7:0]           fuse_mfr,
  input  logic [31:0]          fuse_sn,
  input  logic [15:0]          rom_mfr,
  input  logic [15:0]          rom_sn,
  input  logic                 blk_ready,
  output logic                 blk_valid,
  output logic                 blk_idx,
  output logic [511:0]         blk_data,
  output logic                 bad_mode
);
  localparam int BLK_W   = KEY_W + CHAL_W;
  localparam int SEC_N   = 64;
  localparam int STAT_N  = FUSE_N - SEC_N;
  localparam int ID_W    = 8 + 8 + 16 + FUSE_N + 8 + 32 + 16 + 16;
  localparam int LEN_W   = 64;
  localparam int ZERO_W  = BLK_W - ID_W - 1 - LEN_W;
  localparam int MSG_BITS = BLK_W + ID_W;

  typedef enum logic [1:0] {IDLE, SEND0, SEND1} st_t;
  st_t st;

  logic [BLK_W-1:0] kc_q;
  logic [ID_W-1:0]  id_q;
  logic [ID_W-1:0]  id_d;

  wire illegal  = mode[7] | (|mode[3:0]);
  wire burned   = ~fuse[LOCK_FUSE];
  wire take_all = mode[4] & burned;
  wire take_sec = burned & (mode[4] | mode[5]);
  wire take_sn  = mode[6];
  wire go       = (st == IDLE) && start && !illegal;

  assign id_d = {opcode, mode, key_id,
                 take_sec ? fuse[SEC_N-1:0] : {SEC_N{1'b0}},
                 take_all ? fuse[FUSE_N-1:SEC_N] : {STAT_N{1'b0}},
                 fuse_mfr,
                 take_sn ? fuse_sn : 32'h0,
                 rom_mfr,
                 take_sn ? rom_sn : 16'h0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE;
      bad_mode <= 1'b0;
    end else begin
      bad_mode <= (st == IDLE) && start && illegal;
      case (st)
        IDLE:    if (go) st <= SEND0;
        SEND0:   if (blk_ready) st <= SEND1;
        SEND1:   if (blk_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (go) begin
      kc_q <= {key, challenge};
      id_q <= id_d;
    end

  assign blk_valid = (st != IDLE);
  assign blk_idx   = (st == SEND1);
  assign blk_data  = blk_idx ? {id_q, 1'b1, {ZERO_W{1'b0}}, LEN_W'(MSG_BITS)} : kc_q;

  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_idx && blk_ready |=> blk_valid && blk_idx); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_idx) && $stable(blk_data)); // R10
  AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_idx && blk_ready |=> !blk_valid); // R10
  AST_BAD_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> !blk_valid); // R9
  AST_TAIL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_idx |-> blk_data[319] && blk_data[318:64] == '0 && blk_data[63:0] == 64'd704); // R4
  AST_SN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_idx && !blk_data[502] |-> blk_data[383:352] == '0 && blk_data[335:320] == '0); // R5
  AST_SECRET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_idx && !blk_data[501] && !blk_data[500] |-> blk_data[479:416] == '0); // R6
  AST_STATUS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_idx && !blk_data[500] |-> blk_data[415:392] == '0); // R7
endmodule

// File: tb/test_digest_msg_builder.sv
module test_digest_msg_builder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, blk_ready = 1'b0;
  logic [255:0] key, challenge;
  logic [7:0]   opcode = 8'h08, mode = 8'h00, fuse_mfr = 8'h77;
  logic [15:0]  key_id = 16'h1234, rom_mfr = 16'hCCDD, rom_sn = 16'hEEFF;
  logic [87:0]  fuse;
  logic [31:0]  fuse_sn = 32'h8899AABB;
  logic         blk_valid, blk_idx, bad_mode;
  logic [511:0] blk_data;
  int n_chk = 0, n_bad = 0;

  localparam logic [86:0] FBASE = 87'h3A_5C3E_9D1F_2468_ACE1_357B;
  localparam logic [255:0] KEY0 = {16{16'hA5C3}};
  localparam logic [255:0] CHL0 = {32{8'h5A}};
  localparam logic [511:0] TAIL = {1'b1, 255'b0, 64'd704};

  // {mode, lock fuse value, expect serials, expect secret, expect status}
  localparam logic [11:0] VEC [0:9] = '{
    {8'h00, 1'b1, 3'b000}, {8'h40, 1'b1, 3'b100}, {8'h20, 1'b1, 3'b000},
    {8'h20, 1'b0, 3'b010}, {8'h10, 1'b0, 3'b011}, {8'h30, 1'b0, 3'b011},
    {8'h10, 1'b1, 3'b000}, {8'h70, 1'b0, 3'b111}, {8'h60, 1'b0, 3'b110},
    {8'h50, 1'b1, 3'b100}};

  always #(CLK_PERIOD/2) clk = ~clk;

  digest_msg_builder i_digest_msg_builder (
    .clk, .rst_n, .start, .key, .challenge, .opcode, .mode, .key_id, .fuse,
    .fuse_mfr, .fuse_sn, .rom_mfr, .rom_sn, .blk_ready, .blk_valid, .blk_idx,
    .blk_data, .bad_mode);

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] exp_b1(logic [7:0] m, logic [87:0] f,
                                          logic sn, logic sec, logic stt);
    logic [191:0] id;
    id = {8'h08, m, 16'h1234, sec ? f[63:0] : 64'h0, stt ? f[87:64] : 24'h0,
          8'h77, sn ? 32'h8899AABB : 32'h0, 16'hCCDD, sn ? 16'hEEFF : 16'h0};
    return {id, TAIL[319:0]};
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    key = KEY0; challenge = CHL0; fuse = {1'b1, FBASE};
    repeat (2) @(negedge clk);
    check("R1 valid", {511'b0, blk_valid}, 512'd0);
    check("R1 bad_mode", {511'b0, bad_mode}, 512'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {510'b0, blk_valid, bad_mode}, 512'd0);

    for (int i = 0; i < 10; i++) begin
      logic [511:0] e1;
      mode = VEC[i][11:4];
      fuse = {VEC[i][3], FBASE};
      e1 = exp_b1(mode, fuse, VEC[i][2], VEC[i][1], VEC[i][0]);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R2 block0 valid/idx", {510'b0, blk_valid, blk_idx}, 512'd2);
      check("R2 block0 data", blk_data, {KEY0, CHL0});
      @(negedge clk);
      check("R10 stall hold", {blk_valid, blk_idx, blk_data[510:0]}, {2'b10, CHL0[254:0], KEY0, 1'b0} >> 0 == 0 ? 513'd0 : {1'b1, 1'b0, KEY0[254:0], CHL0});
      blk_ready = 1'b1;
      @(negedge clk);
      check("R10 block1 index", {510'b0, blk_valid, blk_idx}, 512'd3);
      check("R3 R5 R6 R7 block1 fields", blk_data, e1);
      @(negedge clk);
      check("R10 valid drops", {511'b0, blk_valid}, 512'd0);
      blk_ready = 1'b0;
    end

    // R4 and R8 explicitly
    mode = 8'h00; fuse = {1'b0, FBASE};
    start = 1'b1; @(negedge clk); start = 1'b0; blk_ready = 1'b1;
    @(negedge clk);
    check("R4 pad and length", {192'b0, blk_data[319:0]}, {192'b0, TAIL[319:0]});
    check("R8 manufacturer fields", {488'b0, blk_data[391:384], blk_data[351:336]}, {488'b0, 8'h77, 16'hCCDD});
    @(negedge clk); blk_ready = 1'b0;

    // R9 reserved mode values
    foreach (VEC[j]) begin end
    for (int k = 0; k < 3; k++) begin
      mode = (k == 0) ? 8'h80 : (k == 1) ? 8'h41 : 8'h18;
      start = 1'b1; @(negedge clk); start = 1'b0;
      check("R9 flag raised, no block", {510'b0, bad_mode, blk_valid}, 512'd2);
      @(negedge clk);
      check("R9 flag one cycle, no block", {510'b0, bad_mode, blk_valid}, 512'd0);
    end

    // R11 start during a stall, with changed inputs
    mode = 8'h40; fuse = {1'b1, FBASE};
    start = 1'b1; @(negedge clk);
    mode = 8'h80; key = ~KEY0; challenge = ~CHL0; fuse_sn = 32'h0;
    @(negedge clk); start = 1'b0;
    check("R11 no flag from busy start", {511'b0, bad_mode}, 512'd0);
    check("R11 block0 unchanged", blk_data, {KEY0, CHL0});
    blk_ready = 1'b1; @(negedge clk);
    check("R11 block1 unchanged", blk_data, exp_b1(8'h40, {1'b1, FBASE}, 1'b1, 1'b0, 1'b0));
    @(negedge clk); blk_ready = 1'b0;
    check("R11 no extra block", {511'b0, blk_valid}, 512'd0);

    finish_run();
  end
endmodule